// File: doc/BRIEF.md
# Serial EEPROM Word Programmer

This block stores one 16-bit word into a serial EEPROM that takes a 16-bit byte address. A client hands it a word address and a data word on a valid/ready request. The block then claims the EEPROM pins, which are shared with other masters, through a request/grant handshake. Only then does it drive the serial clock, the active-low chip select and the serial data-in line, and sample the serial data-out line.

The word is programmed as two separate byte writes, high byte first. Each byte write starts with status polls that repeat until the device reports ready. A write-enable transaction follows in its own chip-select frame, trailed by one spare clock pulse. Last comes the write frame, which carries the opcode, the byte address and the data byte. If the device stays busy past a timeout measured in milliseconds, the block abandons the word and signals an error without writing. Completion is reported as a one-cycle pulse with an error flag.

Top module: `eeprom_word_writer`

## Requirements
- R1: After a request is accepted, `busReq` goes high and stays high until the completion pulse. Before `busGrant` is seen high, `eeCsN` stays high and `eeSk` stays low. `busReq` is low in the cycle `donePulse` is high.
- R2: `eeSk` idles low. Each bit is placed on `eeDi` while `eeSk` is low and is held stable while `eeSk` is high. Every field is sent most significant bit first. Each SK level lasts `SK_HALF` clocks. `eeDo` is sampled in the last low clock before each rising edge of SK.
- R3: Every command is framed by `eeCsN`. It falls before the first SK rise of the command and rises after the last SK fall.
- R4: A status poll is one frame of 16 SK pulses: opcode 0x05, then 8 bits read from `eeDo` with data-in low. The device is ready when the last bit read (status bit 0) is 0. Polls repeat while that bit is 1. The upper seven status bits are ignored.
- R5: Write enable is a frame of 8 SK pulses carrying opcode 0x06. After CS rises, exactly one SK pulse follows while `eeCsN` is high.
- R6: A byte write is one frame of 32 SK pulses: opcode 0x02, the 16-bit byte address, then the data byte.
- R7: For word address N, data bits 15:8 are written to byte address 2N+1 first, then bits 7:0 to byte address 2N. Each byte gets its own poll / write-enable / write sequence.
- R8: The poll timer restarts at the beginning of each byte's polling and counts `TIMEOUT_MS` units of `CLKS_PER_MS` clocks. If a completed poll still shows busy once the timer has reached its limit, no write enable or write is issued for the word, and the completion pulse carries the error flag.
- R9: `donePulse` is high for exactly one cycle per accepted request. `doneErr` is 0 after a successful word write.
- R10: `reqReady` is high only while the block is idle. A request presented while the block is busy is ignored and produces no extra frames or completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Word write request valid |
| reqReady | output | 1 | Block idle, request will be taken |
| reqAddr | input | 15 | Word address N |
| reqData | input | 16 | Word to store |
| busReq | output | 1 | Request for ownership of the EEPROM pins |
| busGrant | input | 1 | Ownership granted |
| eeSk | output | 1 | Serial clock to the EEPROM |
| eeCsN | output | 1 | Chip select, active low |
| eeDi | output | 1 | Serial data into the EEPROM |
| eeDo | input | 1 | Serial data out of the EEPROM |
| donePulse | output | 1 | One-cycle completion strobe |
| doneErr | output | 1 | Timeout error, valid with `donePulse` |

## Verification
Several properties are checked every cycle:
- Chip select is never driven low without the pin request.
- Data-in holds steady across every SK high phase.
- Each transfer ends on a falling SK edge.
- The completion strobe lasts one cycle and the error flag never appears without it.
- Busy-time requests leave the captured data alone.
- No write enable is issued once a timeout is flagged.

Frame contents need the bench's EEPROM responder, which logs every CS frame and every spare SK pulse. These contents are the opcodes, the address and data bits, the high-then-low byte order, and the number of status polls against a scripted busy count. The same is true of the timeout duration and the recovery after a timeout.

// File: rtl/eew_pkg.sv
package eew_pkg;

  parameter int EE_ADDR_BITS = 16;
  parameter int XFER_MAX     = 16 + EE_ADDR_BITS;
  parameter int XFER_NBW     = $clog2(XFER_MAX + 1);

  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // strobes from control to the serial engine
  typedef struct packed {
    logic                start;
    logic                csLow;
    logic                csHigh;
    logic [XFER_NBW-1:0] nBits;
    logic [XFER_MAX-1:0] word;
  } xferCmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_GRANT, S_POLL, S_POLL_W, S_WREN, S_WREN_W,
    S_TICK, S_TICK_W, S_WRITE, S_WRITE_W, S_FINISH
  } ctrlState_t;

endpackage

// File: rtl/eew_shift.sv
module eew_shift
  import eew_pkg::*;
#(
  parameter int SK_HALF = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  xferCmd_t cmd,
  input  logic     eeDo,
  output logic     eeSk,
  output logic     eeCsN,
  output logic     eeDi,
  output logic     xferDone,
  output logic     statusBit0
);

  localparam int HW = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;

  logic                active;
  logic                skReg;
  logic                csReg;
  logic                doneReg;
  logic                sampledDo;
  logic [HW-1:0]       halfCnt;
  logic [XFER_NBW-1:0] bitsLeft;
  logic [XFER_MAX-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      skReg     <= 1'b0;
      csReg     <= 1'b1;
      doneReg   <= 1'b0;
      sampledDo <= 1'b0;
      halfCnt   <= '0;
      bitsLeft  <= '0;
      shiftReg  <= '0;
    end else begin
      doneReg <= 1'b0;
      if (cmd.csLow)  csReg <= 1'b0;
      if (cmd.csHigh) csReg <= 1'b1;
      if (cmd.start && !active) begin
        active   <= 1'b1;
        skReg    <= 1'b0;
        halfCnt  <= '0;
        bitsLeft <= cmd.nBits;
        shiftReg <= cmd.word << (XFER_MAX - int'(cmd.nBits));
      end else if (active) begin
        if (halfCnt == HW'(SK_HALF - 1)) begin
          halfCnt <= '0;
          if (!skReg) begin
            skReg     <= 1'b1;
            sampledDo <= eeDo;
          end else begin
            skReg    <= 1'b0;
            shiftReg <= shiftReg << 1;
            bitsLeft <= bitsLeft - 1'b1;
            if (bitsLeft == XFER_NBW'(1)) begin
              active  <= 1'b0;
              doneReg <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  assign eeSk       = skReg;
  assign eeCsN      = csReg;
  assign eeDi       = active ? shiftReg[XFER_MAX-1] : 1'b0;
  assign xferDone   = doneReg;
  assign statusBit0 = sampledDo;

  AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> $stable(eeDi));                                   // R2
  AST_DONE_ON_SK_FALL: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> $fell(eeSk));                                 // R2

endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl
  import eew_pkg::*;
#(
  parameter int CLKS_PER_MS = 125000,
  parameter int TIMEOUT_MS  = 10000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [EE_ADDR_BITS-2:0] reqAddr,
  input  logic [15:0]             reqData,
  output logic                    busReq,
  input  logic                    busGrant,
  input  logic                    xferDone,
  input  logic                    statusBit0,
  output xferCmd_t                cmd,
  output logic                    donePulse,
  output logic                    doneErr
);

  localparam int DW  = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int MSW = $clog2(TIMEOUT_MS + 1);

  ctrlState_t              state;
  logic [EE_ADDR_BITS-1:0] addrReg;
  logic [15:0]             dataReg;
  logic                    lowPhase;
  logic                    errFlag;
  logic [DW-1:0]           tickDiv;
  logic [MSW-1:0]          msCnt;
  logic                    timerClr;
  logic [7:0]              curByte;

  assign curByte  = lowPhase ? dataReg[7:0] : dataReg[15:8];
  assign reqReady = (state == S_IDLE);
  assign timerClr = (state == S_GRANT && busGrant) ||
                    (state == S_WRITE_W && xferDone && !lowPhase);

  // millisecond timer for status polling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickDiv <= '0;
      msCnt   <= '0;
    end else if (timerClr) begin
      tickDiv <= '0;
      msCnt   <= '0;
    end else if (tickDiv == DW'(CLKS_PER_MS - 1)) begin
      tickDiv <= '0;
      if (msCnt != MSW'(TIMEOUT_MS)) msCnt <= msCnt + 1'b1;
    end else begin
      tickDiv <= tickDiv + 1'b1;
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.csHigh = xferDone && (state == S_POLL_W || state == S_WREN_W ||
                              state == S_WRITE_W);
    case (state)
      S_POLL: begin
        cmd.start = 1'b1;
        cmd.csLow = 1'b1;
        cmd.nBits = XFER_NBW'(16);
        cmd.word  = XFER_MAX'({OP_RDSR, 8'h00});
      end
      S_WREN: begin
        cmd.start = 1'b1;
        cmd.csLow = 1'b1;
        cmd.nBits = XFER_NBW'(8);
        cmd.word  = XFER_MAX'(OP_WREN);
      end
      S_TICK: begin
        cmd.start = 1'b1;
        cmd.nBits = XFER_NBW'(1);
      end
      S_WRITE: begin
        cmd.start = 1'b1;
        cmd.csLow = 1'b1;
        cmd.nBits = XFER_NBW'(XFER_MAX);
        cmd.word  = {OP_WRITE, addrReg, curByte};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      addrReg   <= '0;
      dataReg   <= '0;
      lowPhase  <= 1'b0;
      errFlag   <= 1'b0;
      busReq    <= 1'b0;
      donePulse <= 1'b0;
      doneErr   <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      doneErr   <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          addrReg  <= {reqAddr, 1'b1};
          dataReg  <= reqData;
          lowPhase <= 1'b0;
          errFlag  <= 1'b0;
          busReq   <= 1'b1;
          state    <= S_GRANT;
        end
        S_GRANT: if (busGrant) state <= S_POLL;
        S_POLL:  state <= S_POLL_W;
        S_POLL_W: if (xferDone) begin
          if (!statusBit0) begin
            state <= S_WREN;
          end else if (msCnt >= MSW'(TIMEOUT_MS)) begin
            errFlag <= 1'b1;
            state   <= S_FINISH;
          end else begin
            state <= S_POLL;
          end
        end
        S_WREN:   state <= S_WREN_W;
        S_WREN_W: if (xferDone) state <= S_TICK;
        S_TICK:   state <= S_TICK_W;
        S_TICK_W: if (xferDone) state <= S_WRITE;
        S_WRITE:  state <= S_WRITE_W;
        S_WRITE_W: if (xferDone) begin
          if (!lowPhase) begin
            lowPhase   <= 1'b1;
            addrReg[0] <= 1'b0;
            state      <= S_POLL;
          end else begin
            state <= S_FINISH;
          end
        end
        S_FINISH: begin
          busReq    <= 1'b0;
          donePulse <= 1'b1;
          doneErr   <= errFlag;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BUSREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> busReq);                             // R1
  AST_NO_WREN_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WREN || state == S_WRITE) |-> !errFlag);       // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> donePulse);                                    // R9
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> $stable(dataReg));             // R10

endmodule

// File: rtl/eeprom_word_writer.sv
module eeprom_word_writer
  import eew_pkg::*;
#(
  parameter int SK_HALF     = 4,
  parameter int CLKS_PER_MS = 125000,
  parameter int TIMEOUT_MS  = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [14:0] reqAddr,
  input  logic [15:0] reqData,
  output logic        busReq,
  input  logic        busGrant,
  output logic        eeSk,
  output logic        eeCsN,
  output logic        eeDi,
  input  logic        eeDo,
  output logic        donePulse,
  output logic        doneErr
);

  xferCmd_t xferCmd;
  logic     xferDone;
  logic     statusBit0;

  eew_ctrl #(.CLKS_PER_MS(CLKS_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .busReq(busReq),
    .busGrant(busGrant), .xferDone(xferDone), .statusBit0(statusBit0),
    .cmd(xferCmd), .donePulse(donePulse), .doneErr(doneErr)
  );

  eew_shift #(.SK_HALF(SK_HALF)) uShift (
    .clk(clk), .rstN(rstN), .cmd(xferCmd), .eeDo(eeDo), .eeSk(eeSk),
    .eeCsN(eeCsN), .eeDi(eeDi), .xferDone(xferDone), .statusBit0(statusBit0)
  );

  AST_CS_NEEDS_OWNERSHIP: assert property (@(posedge clk) disable iff (!rstN)
    !eeCsN |-> busReq);                                        // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);                                 // R9

endmodule

// File: tb/sim_eeprom_word_writer.sv
module sim_eeprom_word_writer;

  localparam int SKH = 2;
  localparam int CPM = 50;
  localparam int TMS = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic busGrant = 1'b0;
  logic doBit = 1'b0;
  logic reqReady, busReq, eeSk, eeCsN, eeDi, donePulse, doneErr;

  always #4 clk = ~clk;

  eeprom_word_writer #(.SK_HALF(SKH), .CLKS_PER_MS(CPM), .TIMEOUT_MS(TMS)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .busReq(busReq), .busGrant(busGrant),
    .eeSk(eeSk), .eeCsN(eeCsN), .eeDi(eeDi), .eeDo(doBit),
    .donePulse(donePulse), .doneErr(doneErr)
  );

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- EEPROM responder ----------------
  logic [63:0] curBits = '0;
  int          curLen = 0;
  logic [63:0] fBits [0:255];
  int          fLen  [0:255];
  int          fCnt = 0;
  int          extraPulses = 0;
  int          busyTarget = 0;
  int          pollCnt = 0;
  bit          alwaysBusy = 1'b0;
  logic [7:0]  statusByte = '0;

  always @(negedge eeCsN) begin
    curBits = '0;
    curLen  = 0;
  end

  always @(posedge eeSk) begin
    if (eeCsN === 1'b0) begin
      curBits = {curBits[62:0], eeDi};
      curLen++;
    end else begin
      extraPulses++;
    end
  end

  always @(negedge eeSk) begin
    if (eeCsN === 1'b0 && curLen >= 8 && curLen < 16 &&
        ((curBits >> (curLen - 8)) & 64'hFF) == 64'h05) begin
      if (curLen == 8) begin
        if (alwaysBusy || pollCnt < busyTarget) statusByte = 8'($urandom) | 8'h01;
        else statusByte = 8'($urandom) & 8'hFE;
        pollCnt++;
      end
      doBit = statusByte[15 - curLen];
    end
  end

  always @(posedge eeCsN) begin
    if (curLen > 0) begin
      if (fCnt < 256) begin
        fBits[fCnt] = curBits;
        fLen[fCnt]  = curLen;
        fCnt++;
      end
      if (curLen == 32 && curBits[31:24] == 8'h02) pollCnt = 0;
      curLen = 0;
      doBit  = 1'b0;
    end
  end

  task automatic clearLog();
    fCnt = 0;
    extraPulses = 0;
    pollCnt = 0;
  endtask

  function automatic logic [63:0] expWrite(input logic [15:0] ba, input logic [7:0] b);
    return {32'h0, 8'h02, ba, b};
  endfunction

  // wait for the completion strobe; returns cycles waited
  task automatic waitDone(output bit err, output bit reqAtDone, output int waited);
    waited = 0;
    while (donePulse !== 1'b1 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(donePulse === 1'b1, "R9", "done pulse seen", donePulse, 1);
    err = doneErr;
    reqAtDone = busReq;
    @(negedge clk);
    chk(donePulse === 1'b0, "R9", "done lasts one cycle", donePulse, 0);
  endtask

  task automatic checkByte(inout int idx, input int busyN,
                           input logic [15:0] ba, input logic [7:0] b);
    int badPoll = 0;
    for (int p = 0; p <= busyN; p++) begin
      if (idx >= fCnt || fLen[idx] != 16 || fBits[idx][15:8] != 8'h05 ||
          fBits[idx][7:0] != 8'h00) badPoll++;
      idx++;
    end
    chk(badPoll == 0, "R4", "status poll frames", badPoll, 0);
    chk(idx < fCnt && fLen[idx] == 8 && fBits[idx][7:0] == 8'h06, "R5",
        "write enable frame", (idx < fCnt) ? fBits[idx] : 64'hDEAD, 64'h06);
    idx++;
    chk(idx < fCnt && fLen[idx] == 32 && fBits[idx] == expWrite(ba, b), "R6",
        "write frame (R7 order)", (idx < fCnt) ? fBits[idx] : 64'hDEAD, expWrite(ba, b));
    idx++;
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [15:0] d, input int busyN,
                         input int grantDelay, input bit poke);
    bit err, reqAtDone;
    int waited, idx, pinViol, frozen;
    clearLog();
    alwaysBusy = 1'b0;
    busyTarget = busyN;
    @(negedge clk);
    chk(reqReady === 1'b1, "R10", "ready when idle", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    pinViol = 0;
    for (int i = 0; i < grantDelay; i++) begin
      if (eeCsN !== 1'b1 || eeSk !== 1'b0 || busReq !== 1'b1) pinViol++;
      @(negedge clk);
    end
    chk(pinViol == 0 && busReq === 1'b1, "R1", "pins idle before grant", pinViol, 0);
    busGrant = 1'b1;
    if (poke) begin
      repeat (20) @(negedge clk);
      reqValid = 1'b1; reqAddr = ~a; reqData = ~d;
      chk(reqReady === 1'b0, "R10", "not ready while busy", reqReady, 0);
      repeat (3) @(negedge clk);
      reqValid = 1'b0;
    end
    waitDone(err, reqAtDone, waited);
    busGrant = 1'b0;
    chk(err == 1'b0, "R9", "no error on success", err, 0);
    chk(reqAtDone == 1'b0, "R1", "pin request dropped at done", reqAtDone, 0);
    frozen = fCnt;
    repeat (200) @(negedge clk);
    chk(fCnt == frozen && fCnt == 2 * (busyN + 3), "R10", "frame count, no extra work",
        fCnt, 2 * (busyN + 3));
    chk(extraPulses == 2, "R5", "spare SK pulses with CS high", extraPulses, 2);
    idx = 0;
    checkByte(idx, busyN, {a, 1'b1}, d[15:8]);
    checkByte(idx, busyN, {a, 1'b0}, d[7:0]);
    chk(eeSk === 1'b0 && eeCsN === 1'b1, "R3", "pins idle after word", {eeSk, eeCsN}, 2'b01);
  endtask

  task automatic doTimeout(input logic [14:0] a, input logic [15:0] d);
    bit err, reqAtDone;
    int waited, bad;
    clearLog();
    alwaysBusy = 1'b1;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    busGrant = 1'b1;
    waitDone(err, reqAtDone, waited);
    busGrant = 1'b0;
    alwaysBusy = 1'b0;
    chk(err == 1'b1, "R8", "timeout error flag", err, 1);
    chk(reqAtDone == 1'b0, "R1", "pin request dropped after timeout", reqAtDone, 0);
    chk(waited >= TMS * CPM, "R8", "timeout not before limit", waited, TMS * CPM);
    bad = 0;
    for (int i = 0; i < fCnt; i++)
      if (fLen[i] != 16 || fBits[i][15:8] != 8'h05) bad++;
    chk(bad == 0 && fCnt >= 2 && extraPulses == 0, "R8", "only polls after timeout", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b1 && busReq === 1'b0 && eeCsN === 1'b1 && eeSk === 1'b0 &&
        donePulse === 1'b0, "R1", "reset state",
        {reqReady, busReq, eeCsN, eeSk, donePulse}, 5'b10100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    doWrite(15'h0000, 16'hA55A, 0, 0, 1'b0);
    doWrite(15'h7FFF, 16'hFFFF, 2, 5, 1'b0);
    doWrite(15'h1234, 16'h0001, 1, 1, 1'b1);
    doTimeout(15'h0042, 16'hBEEF);
    doWrite(15'h0042, 16'h8000, 0, 3, 1'b0);

    // constrained random
    for (int k = 0; k < 6; k++)
      doWrite(15'($urandom), 16'($urandom), int'($urandom % 3), int'($urandom % 6),
              1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule